// File: doc/BRIEF.md
# Serial Shift Unit with Selectable Clocking

This block is the data path of a general-purpose serial port. An 8-bit shift register moves data out on its most significant bit and takes new data into its least significant bit. A 4-bit transfer counter counts shift clocks and raises a sticky overflow flag when it wraps. A 2-bit select field picks the clock for each of the two. They can be clocked by software strobes, or by the rising or falling edge of an external serial clock pin. The counter can also count both pin edges, or count writes of a software toggle bit. In that last mode a master that generates the serial clock itself sees the end of a transfer without waiting for the pin.

Software reaches the block through two write strobes that share one write bus. One strobe writes the control byte and the other loads the shift register. The toggle bit also inverts a driven clock-port value. A master uses it to make the serial clock one half-period at a time.

Top module: `serial_shift_core`

## Requirements
- R1: A control write with `wdata[3:2]` = 00 and `wdata[1]` = 1 is a software strobe. It shifts the shift register one place toward the MSB and increments the counter by one at the same clock edge.
- R2: `dout` is the shift register MSB. During the cycle in which a software strobe is being written, `dout` already shows the bit that becomes the MSB at the end of that cycle.
- R3: The bit that a software strobe shifts into the LSB is the value of `sdi` sampled at the rising clock edge just before the strobe cycle.
- R4: `ctl_rdata` reads as {0, overflow flag (bit 6), 0, both-edges bit (bit 4), select field (bits 3:2), 0, 0}. Bits 1 and 0, which hold the strobe/counter-select bit and the toggle bit, always read as zero.
- R5: With select field 10, every rising edge of `sclk_pin` shifts the register and increments the counter. With select field 11, every falling edge does so. The pin goes through a two-flop synchronizer, so the update happens at the third rising `clk` edge after the pin changes. The shifted-in bit is `sdi` after two flops.
- R6: With an external select and control bit 4 set, the counter counts both edges of `sclk_pin`, while the shift register still uses only the selected edge.
- R7: With an external select and control bit 1 set, the counter ignores pin edges. Each control write with bit 0 set that also carries bit 3 = 1 and bit 1 = 1 increments it. The shift register keeps the selected pin edge.
- R8: Every control write with bit 0 set inverts `clk_port`, in every select mode.
- R9: With select field 00 and no strobe, `sclk_pin` edges change neither the shift register nor the counter.
- R10: A counter wrap from 15 to 0 sets `ovf`, which stays set until a control write with bit 6 set. If a wrap and a clear fall in the same cycle, the wrap wins.
- R11: A write with `wr_dat` loads `wdata` into the shift register, and the load takes priority over any shift in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_pin | input | 1 | External serial clock pin |
| sdi | input | 1 | Serial data in |
| wr_ctl | input | 1 | Write strobe for the control byte |
| wr_dat | input | 1 | Write strobe for the shift register |
| wdata | input | 8 | Software write bus |
| dout | output | 1 | Serial data out |
| clk_port | output | 1 | Driven clock-port value |
| ovf | output | 1 | Sticky counter overflow flag |
| sr_q | output | 8 | Shift register contents |
| cnt_q | output | 4 | Transfer counter |
| ctl_rdata | output | 8 | Control readback |

## Verification
The bench builds the block with its defaults: an 8-bit shift register, a 4-bit counter and two synchronizer stages. At these values a full counter wrap is reached within sixteen strobes, so the overflow flag and the wrap-versus-clear priority are reachable cheaply. The three-edge pin latency is short enough to count exactly. The bench first walks a table of strobe vectors. It then drives each select mode in turn: positive edge, negative edge, both edges, and toggle-clocked counter. Directed cases follow for idle mode, overflow clear and a reset taken mid-run.

// File: rtl/serial_shift_core.sv
module serial_shift_core #(
  parameter int SR_W   = 8,
  parameter int CNT_W  = 4,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_pin,
  input  logic             sdi,
  input  logic             wr_ctl,
  input  logic             wr_dat,
  input  logic [7:0]       wdata,
  output logic             dout,
  output logic             clk_port,
  output logic             ovf,
  output logic [SR_W-1:0]  sr_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [7:0]       ctl_rdata
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_N:0]   sclk_sh;
  logic [SYNC_N-1:0] sdi_sh;
  logic [1:0]        sel_r;
  logic              both_r, csel_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_sh <= '0;
      sdi_sh  <= '0;
    end else begin
      sclk_sh <= {sclk_sh[SYNC_N-1:0], sclk_pin};
      sdi_sh  <= {sdi_sh[SYNC_N-2:0], sdi};
    end

  wire pin_rise = sclk_sh[SYNC_N-1] & ~sclk_sh[SYNC_N];
  wire pin_fall = ~sclk_sh[SYNC_N-1] & sclk_sh[SYNC_N];
  wire pin_sel  = sel_r[0] ? pin_fall : pin_rise;

  wire strobe_go  = wr_ctl & wdata[1] & (wdata[3:2] == 2'b00);
  wire toggle_go  = wr_ctl & wdata[0];
  wire tog_cnt    = toggle_go & wdata[3] & wdata[1];
  wire shift_ext  = sel_r[1] & pin_sel;
  wire cnt_ext    = sel_r[1] & ~csel_r & (both_r ? (pin_rise | pin_fall) : pin_sel);
  wire do_shift   = strobe_go | shift_ext;
  wire do_count   = strobe_go | tog_cnt | cnt_ext;
  wire shift_bit  = strobe_go ? sdi_sh[0] : sdi_sh[SYNC_N-1];
  wire wrap       = do_count & (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_r  <= 2'b00;
      both_r <= 1'b0;
      csel_r <= 1'b0;
    end else if (wr_ctl) begin
      sel_r  <= wdata[3:2];
      both_r <= wdata[4];
      csel_r <= wdata[1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        sr_q <= '0;
    else if (wr_dat)   sr_q <= wdata[SR_W-1:0];
    else if (do_shift) sr_q <= {sr_q[SR_W-2:0], shift_bit};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cnt_q <= '0;
    else if (do_count) cnt_q <= cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     ovf <= 1'b0;
    else if (wrap)                  ovf <= 1'b1;
    else if (wr_ctl && wdata[6])    ovf <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         clk_port <= 1'b0;
    else if (toggle_go) clk_port <= ~clk_port;

  assign dout      = (strobe_go && !wr_dat) ? sr_q[SR_W-2] : sr_q[SR_W-1];
  assign ctl_rdata = {1'b0, ovf, 1'b0, both_r, sel_r, 2'b00};
endmodule

module serial_shift_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_ctl,
  input logic       wr_dat,
  input logic [7:0] wdata,
  input logic       dout,
  input logic       clk_port,
  input logic       ovf,
  input logic [7:0] sr_q,
  input logic [3:0] cnt_q,
  input logic [7:0] ctl_rdata
);
  wire stb = wr_ctl && wdata[1] && (wdata[3:2] == 2'b00) && !wr_dat;

  a_r1_strobe_count: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> cnt_q == ($past(cnt_q) + 1'b1));
  a_r1_strobe_shift: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> sr_q[7:1] == $past(sr_q[6:0]));
  a_r2_dout_early: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> sr_q[7] == $past(dout));
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctl && !wr_dat && ctl_rdata[3:2] == 2'b00) |=> ($stable(sr_q) && $stable(cnt_q)));
  a_r8_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && wdata[0]) |=> clk_port != $past(clk_port));
  a_r8_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ctl && wdata[0]) |=> $stable(clk_port));
  a_r10_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == 4'hF |=> (cnt_q == 4'hF || ovf));
endmodule

bind serial_shift_core serial_shift_core_chk i_chk (.*);

// File: tb/test_serial_shift_core.sv
module test_serial_shift_core;
  logic clk = 0, rst_n = 0, sclk_pin = 0, sdi = 0, wr_ctl = 0, wr_dat = 0;
  logic [7:0] wdata = 0;
  logic dout, clk_port, ovf;
  logic [7:0] sr_q, ctl_rdata;
  logic [3:0] cnt_q;
  int n_chk = 0, n_bad = 0;
  logic dout_seen;
  logic [7:0] m_sr;
  logic [3:0] m_cnt;
  logic m_ovf, m_port;

  always #5 clk = ~clk;

  serial_shift_core i_serial_shift_core (.*);

  localparam logic [8:0] VEC [0:9] = '{
    {1'b1, 8'h01}, {1'b0, 8'h02}, {1'b1, 8'h05}, {1'b1, 8'h0B}, {1'b0, 8'h16},
    {1'b0, 8'h2C}, {1'b1, 8'h59}, {1'b0, 8'hB2}, {1'b1, 8'h65}, {1'b1, 8'hCB}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wctl(logic [7:0] v);
    @(negedge clk); wr_ctl = 1; wdata = v;
    #1 dout_seen = dout;
    @(negedge clk); wr_ctl = 0; wdata = 0;
  endtask

  task automatic wdat(logic [7:0] v);
    @(negedge clk); wr_dat = 1; wdata = v;
    @(negedge clk); wr_dat = 0; wdata = 0;
  endtask

  task automatic pin(logic lvl);
    @(negedge clk); sclk_pin = lvl;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic model_count();
    if (m_cnt == 4'hF) m_ovf = 1;
    m_cnt = m_cnt + 1'b1;
  endtask

  task automatic strobe(logic b);
    @(negedge clk); sdi = b;
    wctl(8'h02);
    m_sr = {m_sr[6:0], b};
    model_count();
  endtask

  task automatic check_state(string req);
    chk(req, sr_q, m_sr);
    chk(req, cnt_q, m_cnt);
    chk(req, ovf, m_ovf);
    chk(req, clk_port, m_port);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 reset sr", sr_q, 0);
    chk("R4 reset cnt", cnt_q, 0);
    chk("R4 reset rdata", ctl_rdata, 0);
    chk("R10 reset ovf", ovf, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R2 R3: strobe vector table
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); sdi = VEC[i][8];
      wctl(8'h02);
      chk("R2 dout in strobe cycle", dout_seen, VEC[i][7]);
      chk("R3 R1 sr after strobe", sr_q, VEC[i][7:0]);
      chk("R1 count", cnt_q, i + 1);
    end
    m_sr = 8'hCB; m_cnt = 4'd10; m_ovf = 0; m_port = 0;
    chk("R4 bits 1:0 zero after strobe", ctl_rdata, 8'h00);

    // R4 R7 R8: write with ext, both, csel, toggle
    wctl(8'h1B);
    m_port = 1; model_count();
    chk("R4 readback", ctl_rdata, 8'h18);
    check_state("R7 toggle clocks counter");

    // R9 idle
    wctl(8'h00);
    pin(1); pin(0);
    check_state("R9 idle pin edges");

    // R11 load
    wdat(8'h3C); m_sr = 8'h3C;
    check_state("R11 load");
    chk("R2 dout is MSB", dout, 0);

    // R5 positive edge
    wctl(8'h08); sdi = 1;
    pin(1); m_sr = {m_sr[6:0], 1'b1}; model_count();
    check_state("R5 rising edge");
    pin(0);
    check_state("R5 falling edge ignored");

    // R5 negative edge
    wctl(8'h0C); sdi = 0;
    pin(1);
    check_state("R5 rising ignored in neg mode");
    pin(0); m_sr = {m_sr[6:0], 1'b0}; model_count();
    check_state("R5 falling edge");

    // R6 both edges for counter
    wctl(8'h18); sdi = 1;
    pin(1); m_sr = {m_sr[6:0], 1'b1}; model_count();
    check_state("R6 rise shifts and counts");
    pin(0); model_count();
    check_state("R6 fall counts only");

    // R7 toggle-clocked counter
    wctl(8'h0A); sdi = 0;
    pin(1); m_sr = {m_sr[6:0], 1'b0};
    check_state("R7 pin shifts without counting");
    wctl(8'h0B); m_port = ~m_port; model_count();
    check_state("R7 R10 toggle wraps counter");
    pin(0);
    check_state("R7 falling ignored");

    // R10 clear
    wctl(8'h40); m_ovf = 0;
    check_state("R10 clear");

    // R8 toggle in software mode
    wctl(8'h01); m_port = ~m_port;
    check_state("R8 toggle in select 00");

    // R10 set beats clear
    while (m_cnt != 4'hF) strobe(0);
    check_state("R10 count to 15");
    @(negedge clk); sdi = 1;
    wctl(8'h42);
    m_sr = {m_sr[6:0], 1'b1}; model_count();
    check_state("R10 wrap wins over clear");

    // reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R4 reset mid-run sr", sr_q, 0);
    chk("R10 reset mid-run ovf", ovf, 0);
    chk("R8 reset mid-run port", clk_port, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule